// File: doc/BRIEF.md
# GPIO Wake-Event Detector

This block watches a single general-purpose input pin and produces a wake-up indication for the power-management logic of a chip. Three configuration inputs set its behaviour. One chooses between edge sensitivity and level sensitivity. One chooses the active direction: falling edge or low level, or rising edge or high level. One inserts or bypasses a debounce filter. The pin is asynchronous. A synchronizer chain brings it into the clock domain before any decision is taken on it.

The debounce filter is a two-state machine. In `DB_STEADY`, the synchronized pin agrees with the accepted value. When the pin differs, the filter moves to `DB_WAIT` and counts agreeing samples. It returns to `DB_STEADY` either by accepting the new value, after `DEB_CYCLES` consecutive differing samples, or by dropping the attempt, when the pin goes back before the count ends. When the filter is bypassed, it is held in `DB_STEADY` and tracks the pin.

The event machine has two states, `EV_IDLE` and `EV_LATCHED`:
- In edge mode, a qualifying edge moves `EV_IDLE` to `EV_LATCHED`. The clear strobe moves `EV_LATCHED` back to `EV_IDLE`.
- In level mode, the machine is held in `EV_IDLE`. The output then shows whether the filtered pin currently matches the active level.
- Any change of the configuration inputs re-arms the edge detector for one cycle.

Top module: `gpio_wake_detect`

## Requirements
- R1: The pin passes through `SYNC_STAGES` (default 2) flops. With debounce off and level mode, a pin change is visible at `wake_evt` after the second rising clock edge.
- R2: `cfg_rise_high` = 0 selects falling-edge or low-level sensitivity. `cfg_rise_high` = 1 selects rising-edge or high-level sensitivity.
- R3: `cfg_level_mode` = 1 makes `wake_evt` a live, unlatched copy of (filtered pin == `cfg_rise_high`).
- R4: `cfg_deb_on` = 0 bypasses the filter, so a pulse of one clock reaches the detector.
- R5: With `cfg_deb_on` = 1, a new value is accepted only after `DEB_CYCLES` consecutive equal synchronized samples. A shorter pulse has no effect on `wake_evt`. A pin change in level mode shows after `DEB_CYCLES`+2 rising edges.
- R6: `cfg_level_mode` = 0 selects edge mode. A qualifying edge sets a sticky flag, shown on `wake_evt` from the third rising edge after the pin change (debounce off), that stays set until `evt_clr`.
- R7: When `evt_clr` and a new qualifying edge fall in the same cycle, the clear wins and the flag ends up clear.
- R8: In a cycle where the configuration inputs differ from the previous cycle, no edge is detected, so reconfiguring never reports a spurious event.
- R9: After reset, `wake_evt` is 0. The synchronizer, the filter and the edge history rest at `IDLE_LEVEL`, and the configuration history rests at edge mode, falling, debounce on.
- R10: In level mode, the sticky flag is forced clear, so returning to edge mode shows no stale event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | 1 | Asynchronous pin input |
| cfg_level_mode | input | 1 | 0 edge, 1 level |
| cfg_rise_high | input | 1 | 0 falling/low, 1 rising/high |
| cfg_deb_on | input | 1 | 1 debounce filter in path, 0 bypass |
| evt_clr | input | 1 | Clears the sticky edge flag |
| wake_evt | output | 1 | Wake-up event: sticky flag (edge) or live match (level) |

## Verification
The bench targets four cases:
- **Filter boundary.** A pulse one sample shorter than the debounce window must leave the output untouched, while a held value must appear exactly on the predicted edge. An off-by-one counter shifts that edge or lets the short pulse through.
- **Clear racing a new edge.** The clear strobe is driven in the very cycle a new edge is detected. A design that gives the edge priority leaves the flag set.
- **Debounce switched off mid-pulse.** The filter is turned off while the synchronized pin disagrees with the accepted value. Without re-arming, the detector sees that jump as a falling edge.
- **Mode round trip.** A flag is latched, the block is sent to level mode and back to edge mode. A design that keeps the old flag reports a stale wake-up.

Long random stretches of pin bursts, clears and configuration changes are compared cycle by cycle against a run-length reference model.

// File: rtl/wake_pkg.sv
package wake_pkg;

    // debounce filter states
    typedef enum logic {
        DB_STEADY = 1'b0,
        DB_WAIT   = 1'b1
    } db_state_e;

    // edge event states
    typedef enum logic {
        EV_IDLE    = 1'b0,
        EV_LATCHED = 1'b1
    } ev_state_e;

    typedef struct packed {
        logic level_mode;
        logic rise_high;
        logic deb_on;
    } wake_cfg_t;

    localparam wake_cfg_t CFG_DEFAULT = '{level_mode: 1'b0, rise_high: 1'b0, deb_on: 1'b1};

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce
    import wake_pkg::*;
#(
    parameter int   HOLD_CYCLES = 8,
    parameter logic RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic din,
    output logic dout,
    output logic held
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    db_state_e      st, st_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic           acc, acc_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= DB_STEADY;
            cnt <= '0;
            acc <= RST_VAL;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            acc <= acc_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        acc_n = acc;
        if (bypass) begin
            st_n  = DB_STEADY;
            cnt_n = '0;
            acc_n = din;
        end else begin
            unique case (st)
                DB_STEADY: begin
                    if (din != acc) begin
                        st_n  = DB_WAIT;
                        cnt_n = ONE;
                    end
                end
                DB_WAIT: begin
                    if (din == acc) begin
                        st_n  = DB_STEADY;
                        cnt_n = '0;
                    end else if (cnt == LAST) begin
                        st_n  = DB_STEADY;
                        cnt_n = '0;
                        acc_n = din;
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
                default: st_n = DB_STEADY;
            endcase
        end
    end

    // outputs
    always_comb begin
        dout = bypass ? din : acc;
        held = acc;
    end
endmodule

// File: rtl/wake_event_fsm.sv
module wake_event_fsm
    import wake_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  wake_cfg_t cfg,
    input  logic      sense,
    input  logic      clr,
    output logic      evt,
    output logic      latched
);
    ev_state_e st, st_n;
    wake_cfg_t cfg_q;
    logic      prev;
    logic      reconf;
    logic      hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= EV_IDLE;
            cfg_q <= CFG_DEFAULT;
            prev  <= RST_VAL;
        end else begin
            st    <= st_n;
            cfg_q <= cfg;
            prev  <= sense;
        end
    end

    always_comb begin
        reconf = (cfg != cfg_q);
        hit    = !reconf && (prev != sense) && (sense == cfg.rise_high);
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            EV_IDLE:    if (!clr && !cfg.level_mode && hit) st_n = EV_LATCHED;
            EV_LATCHED: if (clr || cfg.level_mode)          st_n = EV_IDLE;
            default:    st_n = EV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        latched = (st == EV_LATCHED);
        evt     = cfg.level_mode ? (sense == cfg.rise_high) : latched;
    end
endmodule

// File: rtl/gpio_wake_detect.sv
module gpio_wake_detect
    import wake_pkg::*;
#(
    parameter int   DEB_CYCLES  = 8,
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic cfg_level_mode,
    input  logic cfg_rise_high,
    input  logic cfg_deb_on,
    input  logic evt_clr,
    output logic wake_evt
);
    wake_cfg_t cfg_now;
    logic      pin_sync;
    logic      pin_clean;
    logic      deb_held;
    logic      evt_latched;

    always_comb begin
        cfg_now.level_mode = cfg_level_mode;
        cfg_now.rise_high  = cfg_rise_high;
        cfg_now.deb_on     = cfg_deb_on;
    end

    wake_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_LEVEL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_sync)
    );

    wake_debounce #(
        .HOLD_CYCLES (DEB_CYCLES),
        .RST_VAL     (IDLE_LEVEL)
    ) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .bypass (!cfg_deb_on),
        .din    (pin_sync),
        .dout   (pin_clean),
        .held   (deb_held)
    );

    wake_event_fsm #(
        .RST_VAL (IDLE_LEVEL)
    ) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg_now),
        .sense   (pin_clean),
        .clr     (evt_clr),
        .evt     (wake_evt),
        .latched (evt_latched)
    );
endmodule

// File: rtl/wake_chk.sv
module wake_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_level_mode,
    input logic cfg_rise_high,
    input logic cfg_deb_on,
    input logic evt_clr,
    input logic flag,
    input logic held,
    input logic sync_q
);
    // R7
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr |=> !flag);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !evt_clr && !cfg_level_mode) |=> flag);

    // R10
    level_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_level_mode |=> !flag);

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && ({cfg_level_mode, cfg_rise_high, cfg_deb_on} !=
                   $past({cfg_level_mode, cfg_rise_high, cfg_deb_on}))) |=> !flag);

    // R5
    filter_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_deb_on) && (held != $past(held))) |->
            ((held == $past(sync_q)) && ($past(sync_q) == $past(sync_q, 2))));
endmodule

bind gpio_wake_detect wake_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_level_mode (cfg_level_mode),
    .cfg_rise_high  (cfg_rise_high),
    .cfg_deb_on     (cfg_deb_on),
    .evt_clr        (evt_clr),
    .flag           (evt_latched),
    .held           (deb_held),
    .sync_q         (pin_sync)
);

// File: tb/tb_gpio_wake_detect.sv
`timescale 1ns/1ps
module tb_gpio_wake_detect;
    localparam int DEB = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, pin, lvl, rise, deb, clr;
    logic wake;

    gpio_wake_detect #(.DEB_CYCLES(DEB), .SYNC_STAGES(2), .IDLE_LEVEL(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin), .cfg_level_mode(lvl),
        .cfg_rise_high(rise), .cfg_deb_on(deb), .evt_clr(clr), .wake_evt(wake)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model: run-length debounce
    bit m_s1, m_s2, m_acc, m_last, m_prev, m_flag;
    int m_run;
    logic [2:0] m_cfgq;

    always @(posedge clk) begin
        bit det_old, hit, s;
        logic [2:0] cfg_now;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_acc = 1; m_last = 1; m_prev = 1; m_flag = 0;
            m_run = DEB; m_cfgq = 3'b001;
        end else begin
            det_old = deb ? m_acc : m_s2;
            cfg_now = {lvl, rise, deb};
            hit = (cfg_now == m_cfgq) && (m_prev != det_old) && (det_old == rise);
            if (clr || lvl) m_flag = 0;
            else if (hit)   m_flag = 1;
            m_prev = det_old;
            m_cfgq = cfg_now;
            s = m_s2;
            if (s == m_last) begin
                if (m_run <= DEB) m_run++;
            end else begin
                m_run = 1;
            end
            m_last = s;
            if (!deb || m_run >= DEB) m_acc = s;
            m_s2 = m_s1;
            m_s1 = pin;
        end
    end

    function automatic bit exp_wake();
        bit det;
        det = deb ? m_acc : m_s2;
        return lvl ? (det == rise) : m_flag;
    endfunction

    task automatic chk_model(string tag);
        total++;
        if (wake !== exp_wake()) begin
            bad++;
            $display("FAIL %s model actual=%b expected=%b t=%0t", tag, wake, exp_wake(), $time);
        end
    endtask

    task automatic chk_lit(string tag, bit e);
        total++;
        if (wake !== e) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, wake, e, $time);
        end
    endtask

    task automatic settle(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk_model(tag);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; pin = 1; lvl = 0; rise = 0; deb = 1; clr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_lit("R9 reset", 1'b0);

        // R1: two-flop latency, level high, no debounce
        lvl = 1; rise = 1; deb = 0; pin = 0;
        settle(4, "R1 settle");
        pin = 1;
        @(negedge clk); chk_lit("R1 one edge", 1'b0);
        @(negedge clk); chk_lit("R1 two edges", 1'b1);

        // R2: low-level sensitivity
        rise = 0;
        @(negedge clk); chk_lit("R2 high pin low-active", 1'b0);
        pin = 0;
        settle(1, "R2 wait");
        @(negedge clk); chk_lit("R2 low pin low-active", 1'b1);

        // R5: short pulse rejected, long one accepted on time
        rise = 1; deb = 1; pin = 0;
        settle(10, "R5 settle");
        pin = 1;
        for (int k = 1; k <= DEB - 1; k++) begin
            @(negedge clk); chk_lit("R5 short pulse", 1'b0);
        end
        pin = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); chk_lit("R5 after short pulse", 1'b0);
        end
        pin = 1;
        for (int k = 1; k <= DEB + 3; k++) begin
            @(negedge clk); chk_lit("R5 held value", k >= DEB + 2);
        end

        // R4: bypass lets a one-cycle pulse through
        deb = 0; pin = 0;
        settle(5, "R4 settle");
        pin = 1;
        @(negedge clk); pin = 0; chk_lit("R4 pulse k1", 1'b0);
        @(negedge clk); chk_lit("R4 pulse k2", 1'b1);
        @(negedge clk); chk_lit("R4 pulse k3", 1'b0);

        // R6: sticky falling edge
        lvl = 0; rise = 0; deb = 0; pin = 1;
        settle(5, "R6 settle");
        pin = 0;
        @(negedge clk); chk_lit("R6 k1", 1'b0);
        @(negedge clk); chk_lit("R6 k2", 1'b0);
        @(negedge clk); chk_lit("R6 k3", 1'b1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); chk_lit("R6 sticky", 1'b1);
        end
        clr = 1;
        @(negedge clk); clr = 0; chk_lit("R6 cleared", 1'b0);

        // R7: clear in the same cycle as a new edge
        pin = 1;
        settle(5, "R7 settle");
        pin = 0;
        @(negedge clk);
        @(negedge clk);
        clr = 1;
        @(negedge clk); clr = 0; chk_lit("R7 clear wins", 1'b0);
        @(negedge clk); chk_lit("R7 edge consumed", 1'b0);

        // R8: switching debounce off mid-pulse reports nothing
        deb = 1; pin = 1;
        settle(10, "R8 settle");
        clr = 1; @(negedge clk); clr = 0;
        pin = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); chk_lit("R8 pre", 1'b0);
        end
        deb = 0;
        @(negedge clk); chk_lit("R8 reconfig", 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); chk_lit("R8 after reconfig", 1'b0);
        end

        // R10: level mode drops the latched flag
        pin = 1;
        settle(5, "R10 settle");
        pin = 0;
        settle(4, "R10 latch");
        chk_lit("R10 latched", 1'b1);
        lvl = 1; rise = 1;
        @(negedge clk); chk_lit("R10 level inactive", 1'b0);
        lvl = 0; rise = 0;
        @(negedge clk); chk_lit("R10 no stale flag", 1'b0);
        @(negedge clk); chk_lit("R10 no stale flag later", 1'b0);

        // R3 / R6 random phase against the model
        begin
            int hold = 0;
            for (int c = 0; c < 4000; c++) begin
                @(negedge clk);
                chk_model(lvl ? "R3 random level" : "R6 random edge");
                if (hold == 0) begin
                    pin  = 1'($urandom % 2);
                    hold = 1 + int'($urandom % (2 * DEB + 2));
                end
                hold--;
                if ($urandom % 50 == 0) {lvl, rise, deb} = 3'($urandom);
                clr = ($urandom % 8 == 0);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R-all actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule